// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Change Interrupt

This block is an eight-pin general-purpose I/O port that hangs off a small register bus. Software sets a direction mask, writes an output latch, turns the weak pull-ups on or off, and can hand pins 2 and 3 over to two PWM generators. Every pin is brought in through a two-flop synchronizer. The synchronized levels feed register reads, the change detector, and the alternate-function outputs: two capture inputs and two timer clock inputs.

A change on any pin raises one shared sticky flag. The detector compares the synchronized pin levels against a snapshot, and that snapshot is refreshed each time the pin register is read. The interrupt line is the flag gated by an enable bit. Two resets are provided. Power-on reset clears everything. The warm reset (external pin or watchdog) clears everything except the output latch.

Register map (3-bit address). Offset 0, PINS: reads return the synchronized pin levels and refresh the snapshot; writes load the latch. Offset 1, LAT: the latch, read and write. Offset 2, DIR: direction. Offset 3, CTRL: bit 0 is PUOFF, bit 1 is PWMA_EN, bit 2 is PWMB_EN. Offset 4, STAT: bit 0 is the change flag, write 1 to clear. Offset 5, IEN: bit 0. Offsets 6 and 7 read as zero.

Top module: `gpio_chg_port`

## Requirements
- R1: DIR bit value 1 makes the pin an input and 0 makes it an output, so pin_oe = ~DIR. DIR is 0xFF after either reset.
- R2: A write to offset 0 or offset 1 loads the latch. Power-on reset clears the latch to 0. Warm reset leaves the latch unchanged.
- R3: A read of offset 0 returns pin_in delayed by two clock edges.
- R4: If the synchronized pins differ from the snapshot, STAT bit 0 is set at the next edge. A read of offset 0 (rd_en high) copies the synchronized pins into the snapshot. Both resets clear the snapshot and the synchronizer.
- R5: The change flag stays set until a write to offset 4 with bit 0 high. If a pending mismatch arrives at the same edge as the clear, the flag stays set.
- R6: irq is high exactly when the change flag and IEN bit 0 are both set. Both reset to 0.
- R7: pin_pu[i] is high only when DIR[i] = 1 and CTRL bit 0 (PUOFF) = 0. PUOFF resets to 0.
- R8: When CTRL bit 1 is set, pin 2 drives pwm_a in place of the latch. When CTRL bit 2 is set, pin 3 drives pwm_b in place of the latch. Reads of offset 0 still return the pin levels.
- R9: cap_a, cap_b, tclk_ab and tclk_c are the synchronized levels of pins 0, 1, 4 and 5.
- R10: Reads of offsets 1 to 5 return the register contents (CTRL as {PWMB_EN, PWMA_EN, PUOFF} in bits 2:0, STAT and IEN in bit 0, all other bits 0). Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Warm reset, active low, synchronous, keeps the latch |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; at offset 0 it refreshes the snapshot |
| rd_data | output | 8 | Read data for addr, combinational |
| pin_in | input | 8 | Raw pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Weak pull-up enables |
| pwm_a | input | 1 | PWM source for pin 2 |
| pwm_b | input | 1 | PWM source for pin 3 |
| cap_a | output | 1 | Capture input from pin 0 |
| cap_b | output | 1 | Capture input from pin 1 |
| tclk_ab | output | 1 | Timer clock from pin 4 |
| tclk_c | output | 1 | Timer clock from pin 5 |
| irq | output | 1 | Port-change interrupt |

## Verification
The properties assume both resets are synchronous and that each is held for at least one edge. The synchronizer check also requires two clean edges after reset before it compares against pin_in two edges back, and a counter in the checker enforces that wait. The stimulus changes every input only on the falling clock edge. Both resets are asserted for whole cycles, and the random phase uses only warm resets, which respect the same guard window. The bench model recomputes every output from the register map on each cycle.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int OFS_PINS = 0;
    localparam int OFS_LAT  = 1;
    localparam int OFS_DIR  = 2;
    localparam int OFS_CTRL = 3;
    localparam int OFS_STAT = 4;
    localparam int OFS_IEN  = 5;

    localparam int CTRL_PUOFF  = 0;
    localparam int CTRL_PWMA   = 1;
    localparam int CTRL_PWMB   = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
        if (!clr_n) begin
            stg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int WIDTH     = 8,
    parameter int PWM_A_PIN = 2,
    parameter int PWM_B_PIN = 3
) (
    input  logic [WIDTH-1:0] lat,
    input  logic [WIDTH-1:0] dir,
    input  logic             pu_off,
    input  logic             pwma_en,
    input  logic             pwmb_en,
    input  logic             pwm_a,
    input  logic             pwm_b,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i == PWM_A_PIN) begin : g_pwma
            assign pin_out[i] = pwma_en ? pwm_a : lat[i];
        end else if (i == PWM_B_PIN) begin : g_pwmb
            assign pin_out[i] = pwmb_en ? pwm_b : lat[i];
        end else begin : g_plain
            assign pin_out[i] = lat[i];
        end
        assign pin_oe[i] = ~dir[i];
        assign pin_pu[i] = dir[i] & ~pu_off;
    end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
    parameter int WIDTH      = 8,
    parameter int ADDR_W     = 3,
    parameter int SYNC_STG   = 2,
    parameter int CAP_A_PIN  = 0,
    parameter int CAP_B_PIN  = 1,
    parameter int PWM_A_PIN  = 2,
    parameter int PWM_B_PIN  = 3,
    parameter int TCLK_AB_PIN = 4,
    parameter int TCLK_C_PIN  = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pu,
    input  logic              pwm_a,
    input  logic              pwm_b,
    output logic              cap_a,
    output logic              cap_b,
    output logic              tclk_ab,
    output logic              tclk_c,
    output logic              irq
);
    import gpio_chg_pkg::*;

    localparam logic [WIDTH-1:0] DIR_RST = '1;

    typedef struct packed {
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] dir;
        logic             pu_off;
        logic             pwma_en;
        logic             pwmb_en;
        logic             flag;
        logic             ien;
        logic [WIDTH-1:0] snap;
    } regs_t;

    regs_t            r_d, r_q;
    logic [WIDTH-1:0] pins_s;
    logic             any_rst_n;
    logic             mism;
    logic             hit_pins, hit_lat, hit_dir, hit_ctrl, hit_stat, hit_ien;

    assign any_rst_n = por_n & rst_n;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .clr_n (any_rst_n),
        .din   (pin_in),
        .dout  (pins_s)
    );

    assign hit_pins = (addr == ADDR_W'(OFS_PINS));
    assign hit_lat  = (addr == ADDR_W'(OFS_LAT));
    assign hit_dir  = (addr == ADDR_W'(OFS_DIR));
    assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign hit_stat = (addr == ADDR_W'(OFS_STAT));
    assign hit_ien  = (addr == ADDR_W'(OFS_IEN));
    assign mism     = (pins_s != r_q.snap);

    always_comb begin
        r_d = r_q;
        if (wr_en && (hit_pins || hit_lat)) begin
            r_d.lat = wr_data;
        end
        if (wr_en && hit_dir) begin
            r_d.dir = wr_data;
        end
        if (wr_en && hit_ctrl) begin
            r_d.pu_off  = wr_data[CTRL_PUOFF];
            r_d.pwma_en = wr_data[CTRL_PWMA];
            r_d.pwmb_en = wr_data[CTRL_PWMB];
        end
        if (wr_en && hit_ien) begin
            r_d.ien = wr_data[0];
        end
        r_d.flag = (r_q.flag & ~(wr_en & hit_stat & wr_data[0])) | mism;
        if (rd_en && hit_pins) begin
            r_d.snap = pins_s;
        end
        if (!por_n || !rst_n) begin
            r_d.dir     = DIR_RST;
            r_d.pu_off  = 1'b0;
            r_d.pwma_en = 1'b0;
            r_d.pwmb_en = 1'b0;
            r_d.flag    = 1'b0;
            r_d.ien     = 1'b0;
            r_d.snap    = '0;
            r_d.lat     = por_n ? r_q.lat : '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(OFS_PINS): rd_data = pins_s;
            ADDR_W'(OFS_LAT):  rd_data = r_q.lat;
            ADDR_W'(OFS_DIR):  rd_data = r_q.dir;
            ADDR_W'(OFS_CTRL): begin
                rd_data[CTRL_PUOFF] = r_q.pu_off;
                rd_data[CTRL_PWMA]  = r_q.pwma_en;
                rd_data[CTRL_PWMB]  = r_q.pwmb_en;
            end
            ADDR_W'(OFS_STAT): rd_data[0] = r_q.flag;
            ADDR_W'(OFS_IEN):  rd_data[0] = r_q.ien;
            default:           rd_data = '0;
        endcase
    end

    gpio_pin_mux #(.WIDTH(WIDTH), .PWM_A_PIN(PWM_A_PIN), .PWM_B_PIN(PWM_B_PIN)) u_mux (
        .lat     (r_q.lat),
        .dir     (r_q.dir),
        .pu_off  (r_q.pu_off),
        .pwma_en (r_q.pwma_en),
        .pwmb_en (r_q.pwmb_en),
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu)
    );

    assign cap_a   = pins_s[CAP_A_PIN];
    assign cap_b   = pins_s[CAP_B_PIN];
    assign tclk_ab = pins_s[TCLK_AB_PIN];
    assign tclk_c  = pins_s[TCLK_C_PIN];
    assign irq     = r_q.flag & r_q.ien;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_pu,
    input logic              cap_a,
    input logic              irq
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && addr == ADDR_W'(2)) |=> (pin_oe == ~$past(wr_data))); // R1

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && (addr == ADDR_W'(0) || addr == ADDR_W'(1)))
        |=> (pin_out[1:0] == $past(wr_data[1:0]) && pin_out[WIDTH-1:4] == $past(wr_data[WIDTH-1:4]))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (irq && !(wr_en && ((addr == ADDR_W'(4) && wr_data[0]) || (addr == ADDR_W'(5) && !wr_data[0]))))
        |=> irq); // R5

    AST_IEN_MASK: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && addr == ADDR_W'(5) && !wr_data[0]) |=> !irq); // R6

    AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ((pin_pu & pin_oe) == '0)); // R7

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (since_rst >= 2'd2) |-> (cap_a == $past(pin_in[0], 2))); // R9
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, pin_in = '0;
    logic       pwm_a = 1'b0, pwm_b = 1'b0;
    logic [7:0] rd_data, pin_out, pin_oe, pin_pu;
    logic       cap_a, cap_b, tclk_ab, tclk_c, irq;

    int checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    gpio_chg_port i_gpio_chg_port (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pwm_a(pwm_a),
        .pwm_b(pwm_b), .cap_a(cap_a), .cap_b(cap_b), .tclk_ab(tclk_ab),
        .tclk_c(tclk_c), .irq(irq)
    );

    // reference model state
    logic [7:0] m_lat, m_dir, m_snap;
    logic       m_puoff, m_pwma, m_pwmb, m_flag, m_ien;
    logic [7:0] pipe[$];
    bit         model_live = 0;

    function automatic logic [7:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return pipe[0];
            3'd1: return m_lat;
            3'd2: return m_dir;
            3'd3: return {5'b0, m_pwmb, m_pwma, m_puoff};
            3'd4: return {7'b0, m_flag};
            3'd5: return {7'b0, m_ien};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_out();
        logic [7:0] v = m_lat;
        if (m_pwma) v[2] = pwm_a;
        if (m_pwmb) v[3] = pwm_b;
        return v;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!por_n || !rst_n) begin
            if (!por_n) m_lat = 8'h00;
            m_dir = 8'hFF; m_puoff = 0; m_pwma = 0; m_pwmb = 0;
            m_flag = 0; m_ien = 0; m_snap = 8'h00;
            pipe = {8'h00, 8'h00};
        end else begin
            logic mism;
            mism = (pipe[0] != m_snap);
            if (wr_en) begin
                case (addr)
                    3'd0, 3'd1: m_lat = wr_data;
                    3'd2: m_dir = wr_data;
                    3'd3: begin m_puoff = wr_data[0]; m_pwma = wr_data[1]; m_pwmb = wr_data[2]; end
                    3'd5: m_ien = wr_data[0];
                    default: ;
                endcase
            end
            m_flag = (m_flag && !(wr_en && addr == 3'd4 && wr_data[0])) || mism;
            if (rd_en && addr == 3'd0) m_snap = pipe[0];
            pipe.push_back(pin_in);
            void'(pipe.pop_front());
        end
        model_live = 1;
        #2;
        chk("R1 pin_oe", pin_oe, ~m_dir);
        chk("R2/R8 pin_out", pin_out, m_out());
        chk("R7 pin_pu", pin_pu, m_dir & {8{~m_puoff}});
        chk("R6 irq", {7'b0, irq}, {7'b0, m_flag & m_ien});
        chk("R9 alt inputs", {4'b0, tclk_c, tclk_ab, cap_b, cap_a},
            {4'b0, pipe[0][5], pipe[0][4], pipe[0][1], pipe[0][0]});
        if (addr == 3'd0)      chk("R3 pins read", rd_data, m_rd(addr));
        else if (addr == 3'd4) chk("R4 flag read", rd_data, m_rd(addr));
        else                   chk("R10 reg read", rd_data, m_rd(addr));
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1; rd_en = 0;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 0; wr_en = 0;
        #1 d = rd_data;
    endtask

    task automatic rd_pins();
        @(negedge clk); addr = 3'd0; rd_en = 1; wr_en = 0;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        idle(3);
        por_n = 1; rst_n = 1;
        peek(3'd2, v); chk("R1 dir after POR", v, 8'hFF);
        peek(3'd1, v); chk("R2 latch after POR", v, 8'h00);
        peek(3'd3, v); chk("R7 ctrl after POR", v, 8'h00);

        wr(3'd2, 8'hCF);
        #1 chk("R1 0xCF direction", pin_oe, 8'h30);
        wr(3'd0, 8'hA5);
        #1 chk("R2 write via pins offset", pin_out, 8'hA5);
        wr(3'd3, 8'h01);
        #1 chk("R7 pull-ups off", pin_pu, 8'h00);
        wr(3'd3, 8'h00);
        #1 chk("R7 pull-ups on inputs", pin_pu, 8'hCF);

        // change detection
        @(negedge clk); pin_in = 8'h41;
        idle(1);
        peek(3'd0, v); chk("R3 two-edge latency", v, 8'h41);
        idle(1);
        peek(3'd4, v); chk("R4 flag set on change", v, 8'h01);
        #1 chk("R6 irq masked", {7'b0, irq}, 8'h00);
        wr(3'd5, 8'h01);
        #1 chk("R6 irq enabled", {7'b0, irq}, 8'h01);
        wr(3'd4, 8'h01);
        #1 chk("R5 set wins while mismatch remains", {7'b0, irq}, 8'h01);
        rd_pins();
        wr(3'd4, 8'h01);
        #1 chk("R5 cleared after snapshot", {7'b0, irq}, 8'h00);
        idle(3);
        #1 chk("R4 no change no flag", {7'b0, irq}, 8'h00);

        // PWM override
        wr(3'd3, 8'h06);
        @(negedge clk); pwm_a = 1; pwm_b = 0;
        #1 chk("R8 pwm on pins 2,3", pin_out & 8'h0C, 8'h04);
        @(negedge clk); pin_in = 8'h0C;
        idle(2);
        peek(3'd0, v); chk("R8 reads stay pin levels", v, 8'h0C);

        // warm reset keeps latch
        wr(3'd1, 8'h3C);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        peek(3'd1, v); chk("R2 latch kept on warm reset", v, 8'h3C);
        peek(3'd2, v); chk("R1 dir after warm reset", v, 8'hFF);
        peek(3'd5, v); chk("R6 ien after warm reset", v, 8'h00);
        @(negedge clk); por_n = 0;
        @(negedge clk); por_n = 1;
        peek(3'd1, v); chk("R2 latch cleared on POR", v, 8'h00);
        peek(3'd6, v); chk("R10 unmapped reads zero", v, 8'h00);

        // random phase, checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            addr    = 3'($urandom_range(0, 7));
            wr_en   = ($urandom_range(0, 3) == 0);
            rd_en   = ($urandom_range(0, 2) == 0);
            wr_data = 8'($urandom);
            pwm_a   = 1'($urandom);
            pwm_b   = 1'($urandom);
            if ($urandom_range(0, 5) == 0) pin_in = 8'($urandom);
            rst_n   = ($urandom_range(0, 199) != 0);
        end
        @(negedge clk); rst_n = 1; wr_en = 0; rd_en = 0;
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule